// File: doc/BRIEF.md
# Serial Port Interrupt Event Register Bank

This block gathers thirteen level-style condition signals from a serial port and turns them into one interrupt request line. Each condition is caught on its rising edge into a sticky pending bit. Software clears a pending bit by writing a one to it. A separate enable mask decides which pending bits may drive the interrupt line.

The mask has no directly writable location. Software sets mask bits by writing ones to one address and clears them by writing ones to another, so it never needs a read-modify-write. The current mask can be read back at a third address. An event can be pending while its mask bit is off. It then raises the interrupt as soon as software enables it. The interrupt output is a register: it follows the pending-and-enabled condition one clock later.

Access is through a plain register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `irq_event_bank`

## Requirements
- R1: After reset the mask reads 0, the pending status reads 0 and `irqOut` is 0.
- R2: A write to offset 0x08 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write to offset 0x0C clears every mask bit whose data bit is 1. Writing 0x1FFF there clears the whole mask.
- R4: The mask reads back at offset 0x10 in bits 12:0. A write to offset 0x10 changes neither the mask nor the status.
- R5: The status reads at offset 0x14. Bit n is set in the clock after event input n goes from 0 to 1. The bit positions are: 0 rx trigger, 1 rx empty, 2 rx full, 3 tx empty, 4 tx full, 5 rx overflow, 6 framing error, 7 parity error, 8 rx timeout, 9 modem status change, 10 tx trigger, 11 tx nearly full, 12 tx overflow. A set bit stays set until it is cleared.
- R6: A write to offset 0x14 clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. Writing 0x1FFF clears all pending events.
- R7: If a rising edge on an event arrives in the same cycle as a clearing write to its status bit, the bit stays set.
- R8: An event input held high sets its status bit only once. After that bit is cleared it stays clear until the input has gone low and risen again.
- R9: `irqOut` is a register that equals the OR of (status AND mask) from the previous clock. A pending event whose mask bit was off raises `irqOut` once the bit is enabled.
- R10: Reads of offsets 0x08, 0x0C and any unmapped offset return 0. Bits above bit 12 always read 0. Data bits above bit 12 of a write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (8) | Byte offset for both reads and writes |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Read data for `addr`, combinational |
| evtLevel | input | NUM_EVT (13) | Event condition levels; bit n is the source of status bit n |
| irqOut | output | 1 | Registered interrupt request |

## Verification
Two things can land on one status bit in the same cycle: a software clear of that bit, and a fresh rising edge of its event. The bench provokes this on purpose. It first makes bit 5 pending with a single pulse. It then raises event 5 in the same cycle that it writes 0x20 to the status offset, and it expects bit 5 to read back as set. The random phase can also produce this overlap on any bit. There, the reference model, which applies the clear before it ORs in the edges, judges every read and every `irqOut` value.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam logic [7:0] OFS_MASK_SET = 8'h08;
  localparam logic [7:0] OFS_MASK_CLR = 8'h0C;
  localparam logic [7:0] OFS_MASK_RD  = 8'h10;
  localparam logic [7:0] OFS_STATUS   = 8'h14;

  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic statusClr;
    logic readMask;
    logic readStatus;
  } bankStrobes_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobes_t      strb
);

  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_MASK_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_MASK_CLR);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MASK_RD);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);

  always_comb begin
    strb            = '0;
    strb.maskSet    = wrEn && (addr == A_SET);
    strb.maskClr    = wrEn && (addr == A_CLR);
    strb.statusClr  = wrEn && (addr == A_STS);
    strb.readMask   = (addr == A_MSK);
    strb.readStatus = (addr == A_STS);
  end

endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int NUM_EVT = 13,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobes_t       strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_EVT-1:0] evtLevel,
  output logic [NUM_EVT-1:0] maskQ,
  output logic [NUM_EVT-1:0] statusQ,
  output logic               irqOut,
  output logic [DATA_W-1:0]  rdData
);

  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] evtPrev;
  logic [NUM_EVT-1:0] evtRise;
  logic [NUM_EVT-1:0] wrBits;
  logic [NUM_EVT-1:0] statusNext;
  logic [NUM_EVT-1:0] maskNext;
  logic               unusedWrBits;

  assign wrBits       = wrData[NUM_EVT-1:0];
  assign unusedWrBits = ^wrData[DATA_W-1:NUM_EVT];
  assign evtRise      = evtLevel & ~evtPrev;

  // Per-bit next state: a clear write loses against a fresh edge.
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    logic clrHit;
    assign clrHit        = strb.statusClr & wrBits[i];
    assign statusNext[i] = evtRise[i] | (statusQ[i] & ~clrHit);
    assign maskNext[i]   = (maskQ[i] | (strb.maskSet & wrBits[i]))
                           & ~(strb.maskClr & wrBits[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtPrev <= '0;
      statusQ <= '0;
      maskQ   <= '0;
      irqOut  <= 1'b0;
    end else begin
      evtPrev <= evtLevel;
      statusQ <= statusNext;
      maskQ   <= maskNext;
      irqOut  <= |(statusQ & maskQ);
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.readMask)   rdData = {{PAD_W{1'b0}}, maskQ};
    if (strb.readStatus) rdData = {{PAD_W{1'b0}}, statusQ};
  end

endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_EVT = 13,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_EVT-1:0] evtLevel,
  output logic               irqOut
);

  bankStrobes_t       strb;
  logic [NUM_EVT-1:0] maskQ;
  logic [NUM_EVT-1:0] statusQ;

  irq_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  irq_bank_dp #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .evtLevel (evtLevel),
    .maskQ    (maskQ),
    .statusQ  (statusQ),
    .irqOut   (irqOut),
    .rdData   (rdData)
  );

endmodule

// File: rtl/irq_event_bank_chk.sv
module irq_event_bank_chk #(
  parameter int NUM_EVT = 13,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_EVT-1:0] wrLow,
  input logic               irqOut,
  input logic [NUM_EVT-1:0] maskQ,
  input logic [NUM_EVT-1:0] statusQ
);

  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(8'h14);

  p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SET) |=> ((maskQ & $past(wrLow)) == $past(wrLow)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_CLR) |=> ((maskQ & $past(wrLow)) == '0));

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (addr == A_SET || addr == A_CLR)) |=> $stable(maskQ));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == A_STS) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & maskQ)) |=> irqOut);

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusQ & maskQ)) |=> !irqOut);

endmodule

bind irq_event_bank irq_event_bank_chk #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrLow   (wrData[NUM_EVT-1:0]),
  .irqOut  (irqOut),
  .maskQ   (maskQ),
  .statusQ (statusQ)
);

// File: tb/sim_irq_event_bank.sv
module sim_irq_event_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NE-1:0] evtLevel = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  logic [NE-1:0] mMask, mStatus, mPrev;
  logic          mIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_event_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evtLevel(evtLevel), .irqOut(irqOut)
  );

  // Behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = '0; mStatus = '0; mPrev = '0; mIrq = 1'b0;
    end else begin
      logic [NE-1:0] rise, clr, st, cl;
      rise = evtLevel & ~mPrev;
      clr  = (wrEn && addr == 8'h14) ? wrData[NE-1:0] : '0;
      st   = (wrEn && addr == 8'h08) ? wrData[NE-1:0] : '0;
      cl   = (wrEn && addr == 8'h0C) ? wrData[NE-1:0] : '0;
      mIrq    = |(mStatus & mMask);
      mStatus = (mStatus & ~clr) | rise;
      mMask   = (mMask | st) & ~cl;
      mPrev   = evtLevel;
    end
  end

  function automatic logic [31:0] modelRead(logic [7:0] a);
    if (a == 8'h10) return {19'd0, mMask};
    if (a == 8'h14) return {19'd0, mStatus};
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (running && rstN) begin
      chk("R9 irqOut", {31'd0, irqOut}, {31'd0, mIrq});
      if (addr == 8'h10)      chk("R4 mask read", rdData, modelRead(addr));
      else if (addr == 8'h14) chk("R5 status read", rdData, modelRead(addr));
      else                    chk("R10 other read", rdData, modelRead(addr));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [NE-1:0] ev);
    @(negedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d; evtLevel = ev;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic setEvt(logic [NE-1:0] ev);
    @(negedge clk); #1;
    evtLevel = ev;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    addr = a; #1;
    v = rdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    @(negedge clk); #1; rstN = 1'b1; running = 1'b1;

    // R1 reset state
    rd(8'h10, v); chk("R1 mask after reset", v, 0);
    rd(8'h14, v); chk("R1 status after reset", v, 0);
    chk("R1 irq after reset", {31'd0, irqOut}, 0);

    // R5 edge latch on bit 3, stays while masked
    setEvt(13'h0008); setEvt(13'h0000); idle(2);
    rd(8'h14, v); chk("R5 tx empty latched", v, 32'h8);
    chk("R9 masked pending no irq", {31'd0, irqOut}, 0);

    // R2 enable, R9 pending becomes visible
    wr(8'h08, 32'h0008, '0); idle(2);
    rd(8'h10, v); chk("R2 mask set", v, 32'h8);
    chk("R9 irq after enable", {31'd0, irqOut}, 1);
    wr(8'h08, 32'h0021, '0);
    rd(8'h10, v); chk("R2 zeros keep bits", v, 32'h29);

    // R4 write to mask read location ignored
    wr(8'h10, 32'h1FFF, '0);
    rd(8'h10, v); chk("R4 mask unchanged", v, 32'h29);
    rd(8'h14, v); chk("R4 status unchanged", v, 32'h8);

    // R3 disable
    wr(8'h0C, 32'h0001, '0);
    rd(8'h10, v); chk("R3 mask clear bit0", v, 32'h28);

    // R6 clear semantics
    wr(8'h14, 32'h0000, '0);
    rd(8'h14, v); chk("R6 zero write keeps", v, 32'h8);
    wr(8'h14, 32'h0008, '0); idle(2);
    rd(8'h14, v); chk("R6 one write clears", v, 0);
    chk("R9 irq drops after clear", {31'd0, irqOut}, 0);

    // R7 clear coinciding with new edge on bit 5
    setEvt(13'h0020); setEvt(13'h0000); idle(1);
    rd(8'h14, v); chk("R7 bit5 pending", v, 32'h20);
    wr(8'h14, 32'h0020, 13'h0020);
    rd(8'h14, v); chk("R7 edge wins over clear", v, 32'h20);

    // R8 held level does not relatch
    wr(8'h14, 32'h0020, 13'h0020); idle(3);
    rd(8'h14, v); chk("R8 held level no relatch", v, 0);
    setEvt(13'h0000); setEvt(13'h0020); idle(1);
    rd(8'h14, v); chk("R8 new edge latches", v, 32'h20);
    setEvt(13'h0000);

    // R6 / R3 full clears
    setEvt(13'h1FFF); setEvt(13'h0000); idle(1);
    rd(8'h14, v); chk("R5 all sources latch", v, 32'h1FFF);
    wr(8'h14, 32'h1FFF, '0);
    rd(8'h14, v); chk("R6 clear all", v, 0);
    wr(8'h08, 32'hFFFF_FFFF, '0);
    rd(8'h10, v); chk("R10 upper data ignored", v, 32'h1FFF);
    wr(8'h0C, 32'h1FFF, '0);
    rd(8'h10, v); chk("R3 disable all", v, 0);

    // R10 write-only and unmapped offsets read zero
    wr(8'h08, 32'h0003, '0);
    rd(8'h08, v); chk("R10 enable reads zero", v, 0);
    rd(8'h0C, v); chk("R10 disable reads zero", v, 0);
    rd(8'h04, v); chk("R10 unmapped reads zero", v, 0);

    // Random traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      evtLevel = NE'($urandom);
      wrEn = ($urandom % 3) == 0;
      case ($urandom % 5)
        0: addr = 8'h08;
        1: addr = 8'h0C;
        2: addr = 8'h10;
        3: addr = 8'h14;
        default: addr = 8'h04;
      endcase
      wrData = $urandom;
    end
    @(negedge clk); #1; wrEn = 1'b0;
    idle(2);
    running = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule